// File: doc/BRIEF.md
# External Memory Access Router

This block sits between a processor's data-memory port and two places that data can live: an 8 KB on-chip RAM and an off-chip byte-wide bus. An 8-bit control register chooses how addresses are routed, whether the off-chip bus shares its low address byte with the data pins, which of two physical port groups carries the bus, and how long the address-latch strobe stays high and low.

Each access starts with a one-cycle `req` pulse while the block is idle. The block forms the effective address and routes the access to on-chip RAM or to the off-chip bus. For a short (8-bit) address, the upper address byte comes from an external high-address latch value or from a page register, depending on the routing mode. The access ends with a one-cycle `done` pulse, and read data is valid on `rdata` in that same cycle. The live configuration is sampled only when an access is accepted.

Off-chip cycles take one of two forms. With a shared bus, the block drives the address, holds the latch strobe high for N clocks and then low for N clocks, and finishes with a one-clock read or write strobe. With separate pins, the read or write strobe follows the address directly.

Top module: `xmem_router`

## Requirements
- R1: After reset `cfg_rdata` reads 8'h03. Writes through `cfg_we`/`cfg_wdata` update bits 5..0. Bits 7..6 always read 0, whatever is written. Bit 5 is the port group, bit 4 the pin style (1 = separate pins), bits 3..2 the routing mode, and bits 1..0 the strobe width code.
- R2: In routing mode 00 every access goes on-chip. `ram_addr` is the low 13 bits of the effective address, so addresses above 8 KB alias into the RAM.
- R3: In mode 01, an effective address below 16'h2000 goes on-chip and an address at or above 16'h2000 goes off-chip. For a short access, the upper byte of the effective address is `hi_latch`.
- R4: In mode 10 the 8 KB split of R3 applies. For a short access, the upper byte of the effective address is `page_sel`.
- R5: In mode 11 every access goes off-chip, and a short access takes its upper byte from `page_sel`. In every mode, a 16-bit access (`short_addr`=0) uses its own upper byte.
- R6: With the shared bus (bit 4 = 0), `xb_ale` is high for N clocks and then low for N clocks before the data strobe rises, where N = width code + 1. `xb_ad` carries the low address byte while `xb_ale` is high, and `done` is seen 2N+2 clocks after the access is requested.
- R7: With separate pins (bit 4 = 1), `xb_ale` never rises and the width code has no effect. `xb_alo` carries the low address byte, and `done` is seen 3 clocks after the request.
- R8: `xb_upper` equals bit 5 of the configuration that was sampled at the start of an off-chip access.
- R9: Every read or write strobe (`xb_rd`, `xb_wr`) and every `done` lasts one clock. A write presents `wdata` on `xb_ad` while `xb_wr` is high. A read returns the off-chip or on-chip byte on `rdata` in the `done` cycle, and an on-chip access shows `done` 3 clocks after the request.
- R10: A configuration write made while an access is in flight changes `cfg_rdata` at once, but does not change the routing or timing of that access. It applies from the next access on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write enable |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read value |
| page_sel | input | AW-SHORT_W | Page register value, used as the upper byte for short accesses |
| hi_latch | input | AW-SHORT_W | High-address port latch value, used as the upper byte in mode 01 |
| req | input | 1 | Access request pulse, accepted when idle |
| wr | input | 1 | 1 = write, 0 = read |
| short_addr | input | 1 | 1 = 8-bit address access |
| addr | input | AW | Access address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, valid with done |
| done | output | 1 | One-cycle access completion |
| ram_en | output | 1 | On-chip RAM enable |
| ram_we | output | 1 | On-chip RAM write enable |
| ram_addr | output | LOCAL_AW | On-chip RAM address |
| ram_wdata | output | DW | On-chip RAM write data |
| ram_rdata | input | DW | On-chip RAM read data (one-cycle latency) |
| xb_upper | output | 1 | Off-chip bus on the upper port group |
| xb_ahi | output | AW-SHORT_W | Off-chip upper address byte |
| xb_alo | output | SHORT_W | Off-chip low address byte (separate-pin style only) |
| xb_ad | output | DW | Shared address/data or data pins |
| xb_ad_oe | output | 1 | Output enable for xb_ad |
| xb_din | input | DW | Data read from the off-chip bus |
| xb_ale | output | 1 | Address latch strobe |
| xb_rd | output | 1 | Off-chip read strobe |
| xb_wr | output | 1 | Off-chip write strobe |

## Verification
Each access type has its own latency, counted in falling edges from the one that raises `req`. An on-chip access shows `done` at the third falling edge. A separate-pin off-chip access also shows `done` at the third, with its strobe at the second. A shared-bus access shows `done` at edge 2N+2, after N falling edges with the latch strobe high and N with it low. The bench samples every output on falling edges and drives every input there too. It counts the edges up to `done` and checks each count against these numbers, which also proves that `rdata` is valid in the `done` cycle. For the change-during-access case, the new setting is written at the second falling edge of a width-4 shared-bus read. The bench then checks that the running access keeps all 10 of its cycles and that the next access follows the new routing.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  typedef enum logic [1:0] {
    RT_LOCAL       = 2'b00,
    RT_SPLIT_LATCH = 2'b01,
    RT_SPLIT_PAGE  = 2'b10,
    RT_REMOTE      = 2'b11
  } route_mode_t;

  // Live bits 5..0 of the control register, MSB first.
  typedef struct packed {
    logic        upper_grp;
    logic        split_bus;
    route_mode_t mode;
    logic [1:0]  strobe_w;
  } xcfg_t;

  localparam int CFG_W = 8;
  localparam xcfg_t CFG_RST = xcfg_t'(6'b000011);
endpackage

// File: rtl/xmem_cfg_reg.sv
module xmem_cfg_reg
  import xmem_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output xcfg_t            cfg,
  output logic [CFG_W-1:0] rdata
);
  localparam int LIVE_W = $bits(xcfg_t);

  always_ff @(posedge clk) begin
    if (rst) cfg <= CFG_RST;
    else if (we) cfg <= xcfg_t'(wdata[LIVE_W-1:0]);
  end

  assign rdata = {{(CFG_W-LIVE_W){1'b0}}, cfg};
endmodule

// File: rtl/xmem_route.sv
module xmem_route
  import xmem_pkg::*;
#(
  parameter int AW       = 16,
  parameter int SHORT_W  = 8,
  parameter int LOCAL_AW = 13
) (
  input  route_mode_t          mode,
  input  logic                 short_addr,
  input  logic [AW-1:0]        addr,
  input  logic [AW-SHORT_W-1:0] hi_latch,
  input  logic [AW-SHORT_W-1:0] page_sel,
  output logic [AW-1:0]        eff_addr,
  output logic                 remote
);
  logic [AW-SHORT_W-1:0] hi_src;

  always_comb begin
    hi_src   = (mode == RT_SPLIT_LATCH) ? hi_latch : page_sel;
    eff_addr = short_addr ? {hi_src, addr[SHORT_W-1:0]} : addr;
    unique case (mode)
      RT_LOCAL:  remote = 1'b0;
      RT_REMOTE: remote = 1'b1;
      default:   remote = |eff_addr[AW-1:LOCAL_AW];
    endcase
  end
endmodule

// File: rtl/xmem_seq.sv
module xmem_seq
  import xmem_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 8,
  parameter int SHORT_W  = 8,
  parameter int LOCAL_AW = 13
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req,
  input  logic                  wr,
  input  logic [AW-1:0]         eff_addr,
  input  logic                  remote,
  input  logic [DW-1:0]         wdata,
  input  xcfg_t                 cfg,
  output logic [DW-1:0]         rdata,
  output logic                  done,
  output logic                  ram_en,
  output logic                  ram_we,
  output logic [LOCAL_AW-1:0]   ram_addr,
  output logic [DW-1:0]         ram_wdata,
  input  logic [DW-1:0]         ram_rdata,
  output logic                  xb_upper,
  output logic [AW-SHORT_W-1:0] xb_ahi,
  output logic [SHORT_W-1:0]    xb_alo,
  output logic [DW-1:0]         xb_ad,
  output logic                  xb_ad_oe,
  input  logic [DW-1:0]         xb_din,
  output logic                  xb_ale,
  output logic                  xb_rd,
  output logic                  xb_wr
);
  typedef enum logic [2:0] {
    S_IDLE, S_LWAIT, S_LCAP, S_AHI, S_ALO, S_DSTB, S_DEND
  } st_t;

  st_t            state;
  logic           wr_q;
  logic [DW-1:0]  wd_q;
  logic [1:0]     wid_q;
  logic [1:0]     cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      wr_q      <= 1'b0;
      wd_q      <= '0;
      wid_q     <= '0;
      cnt       <= '0;
      rdata     <= '0;
      done      <= 1'b0;
      ram_en    <= 1'b0;
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
      xb_upper  <= 1'b0;
      xb_ahi    <= '0;
      xb_alo    <= '0;
      xb_ad     <= '0;
      xb_ad_oe  <= 1'b0;
      xb_ale    <= 1'b0;
      xb_rd     <= 1'b0;
      xb_wr     <= 1'b0;
    end else begin
      done   <= 1'b0;
      ram_en <= 1'b0;
      xb_rd  <= 1'b0;
      xb_wr  <= 1'b0;
      unique case (state)
        S_IDLE: if (req) begin
          wr_q  <= wr;
          wd_q  <= wdata;
          wid_q <= cfg.strobe_w;
          if (!remote) begin
            ram_en    <= 1'b1;
            ram_we    <= wr;
            ram_addr  <= eff_addr[LOCAL_AW-1:0];
            ram_wdata <= wdata;
            state     <= S_LWAIT;
          end else begin
            xb_upper <= cfg.upper_grp;
            xb_ahi   <= eff_addr[AW-1:SHORT_W];
            if (cfg.split_bus) begin
              xb_alo   <= eff_addr[SHORT_W-1:0];
              xb_ad    <= wdata;
              xb_ad_oe <= wr;
              state    <= S_DSTB;
            end else begin
              xb_alo   <= '0;
              xb_ad    <= DW'(eff_addr[SHORT_W-1:0]);
              xb_ad_oe <= 1'b1;
              xb_ale   <= 1'b1;
              cnt      <= cfg.strobe_w;
              state    <= S_AHI;
            end
          end
        end
        S_LWAIT: state <= S_LCAP;
        S_LCAP: begin
          if (!wr_q) rdata <= ram_rdata;
          done  <= 1'b1;
          state <= S_IDLE;
        end
        S_AHI: begin
          if (cnt == '0) begin
            xb_ale <= 1'b0;
            cnt    <= wid_q;
            state  <= S_ALO;
          end else begin
            cnt <= cnt - 2'd1;
          end
        end
        S_ALO: begin
          if (cnt == '0) begin
            xb_ad    <= wd_q;
            xb_ad_oe <= wr_q;
            xb_rd    <= !wr_q;
            xb_wr    <= wr_q;
            state    <= S_DEND;
          end else begin
            cnt <= cnt - 2'd1;
          end
        end
        S_DSTB: begin
          xb_rd <= !wr_q;
          xb_wr <= wr_q;
          state <= S_DEND;
        end
        S_DEND: begin
          if (!wr_q) rdata <= xb_din;
          done     <= 1'b1;
          xb_ad_oe <= 1'b0;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xmem_router.sv
module xmem_router
  import xmem_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 8,
  parameter int SHORT_W  = 8,
  parameter int LOCAL_AW = 13
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_we,
  input  logic [7:0]            cfg_wdata,
  output logic [7:0]            cfg_rdata,
  input  logic [AW-SHORT_W-1:0] page_sel,
  input  logic [AW-SHORT_W-1:0] hi_latch,
  input  logic                  req,
  input  logic                  wr,
  input  logic                  short_addr,
  input  logic [AW-1:0]         addr,
  input  logic [DW-1:0]         wdata,
  output logic [DW-1:0]         rdata,
  output logic                  done,
  output logic                  ram_en,
  output logic                  ram_we,
  output logic [LOCAL_AW-1:0]   ram_addr,
  output logic [DW-1:0]         ram_wdata,
  input  logic [DW-1:0]         ram_rdata,
  output logic                  xb_upper,
  output logic [AW-SHORT_W-1:0] xb_ahi,
  output logic [SHORT_W-1:0]    xb_alo,
  output logic [DW-1:0]         xb_ad,
  output logic                  xb_ad_oe,
  input  logic [DW-1:0]         xb_din,
  output logic                  xb_ale,
  output logic                  xb_rd,
  output logic                  xb_wr
);
  xcfg_t         cfg;
  logic [AW-1:0] eff_addr;
  logic          remote;

  xmem_cfg_reg u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata),
    .cfg(cfg), .rdata(cfg_rdata)
  );

  xmem_route #(.AW(AW), .SHORT_W(SHORT_W), .LOCAL_AW(LOCAL_AW)) u_route (
    .mode(cfg.mode), .short_addr(short_addr), .addr(addr),
    .hi_latch(hi_latch), .page_sel(page_sel),
    .eff_addr(eff_addr), .remote(remote)
  );

  xmem_seq #(.AW(AW), .DW(DW), .SHORT_W(SHORT_W), .LOCAL_AW(LOCAL_AW)) u_seq (
    .clk(clk), .rst(rst), .req(req), .wr(wr), .eff_addr(eff_addr),
    .remote(remote), .wdata(wdata), .cfg(cfg),
    .rdata(rdata), .done(done),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .xb_upper(xb_upper), .xb_ahi(xb_ahi), .xb_alo(xb_alo),
    .xb_ad(xb_ad), .xb_ad_oe(xb_ad_oe), .xb_din(xb_din),
    .xb_ale(xb_ale), .xb_rd(xb_rd), .xb_wr(xb_wr)
  );
endmodule

// File: rtl/xmem_router_chk.sv
module xmem_router_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [7:0]    cfg_rdata,
  input logic          done,
  input logic          ram_en,
  input logic [DW-1:0] xb_ad,
  input logic          xb_ale,
  input logic          xb_rd,
  input logic          xb_wr
);
  a_r1_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
    cfg_rdata[7:6] == 2'b00);

  a_r9_rd_one_clk: assert property (@(posedge clk) disable iff (rst)
    xb_rd |=> !xb_rd);

  a_r9_wr_one_clk: assert property (@(posedge clk) disable iff (rst)
    xb_wr |=> !xb_wr);

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r2_single_target: assert property (@(posedge clk) disable iff (rst)
    !(ram_en && (xb_ale || xb_rd || xb_wr)));

  a_r6_no_ale_in_data: assert property (@(posedge clk) disable iff (rst)
    (xb_rd || xb_wr) |-> !xb_ale);

  a_r6_addr_held_at_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(xb_ale) |-> $stable(xb_ad));
endmodule

bind xmem_router xmem_router_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .cfg_rdata(cfg_rdata), .done(done),
  .ram_en(ram_en), .xb_ad(xb_ad), .xb_ale(xb_ale),
  .xb_rd(xb_rd), .xb_wr(xb_wr)
);

// File: tb/xmem_router_bench.sv
`timescale 1ns/1ps
module xmem_router_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic [7:0]  page_sel = '0;
  logic [7:0]  hi_latch = '0;
  logic        req = 1'b0, wr = 1'b0, short_addr = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        done;
  logic        ram_en, ram_we;
  logic [12:0] ram_addr;
  logic [7:0]  ram_wdata;
  logic [7:0]  ram_rdata = '0;
  logic        xb_upper;
  logic [7:0]  xb_ahi, xb_alo, xb_ad;
  logic        xb_ad_oe;
  logic [7:0]  xb_din = '0;
  logic        xb_ale, xb_rd, xb_wr;

  int vectors = 0;
  int miscompares = 0;

  always #2.5 clk = ~clk;

  xmem_router u_xmem_router (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .page_sel(page_sel), .hi_latch(hi_latch),
    .req(req), .wr(wr), .short_addr(short_addr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .done(done),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .xb_upper(xb_upper), .xb_ahi(xb_ahi), .xb_alo(xb_alo),
    .xb_ad(xb_ad), .xb_ad_oe(xb_ad_oe), .xb_din(xb_din),
    .xb_ale(xb_ale), .xb_rd(xb_rd), .xb_wr(xb_wr)
  );

  // On-chip RAM model with one-cycle read latency.
  logic [7:0] mem [8192];
  always @(posedge clk) if (ram_en) begin
    if (ram_we) mem[ram_addr] <= ram_wdata;
    ram_rdata <= mem[ram_addr];
  end

  function automatic logic [7:0] ext_pat(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  // Per-access observations.
  int          lat, hi_cnt, lo_cnt;
  logic        saw_ram, saw_ale, saw_stb, got_done;
  logic [12:0] r_addr;
  logic        e_wr, e_upper;
  logic [15:0] e_addr;
  logic [7:0]  e_data, lat_lo, got;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic access(input logic w, input logic sh, input logic [15:0] a,
                        input logic [7:0] d);
    lat = 0; hi_cnt = 0; lo_cnt = 0;
    saw_ram = 0; saw_ale = 0; saw_stb = 0; got_done = 0;
    r_addr = '0; e_wr = 0; e_upper = 0; e_addr = '0; e_data = '0;
    lat_lo = '0; got = '0;
    @(negedge clk);
    req = 1'b1; wr = w; short_addr = sh; addr = a; wdata = d;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      req = 1'b0;
      lat++;
      if (ram_en) begin saw_ram = 1; r_addr = ram_addr; end
      if (xb_ale) begin
        hi_cnt++; saw_ale = 1; lat_lo = xb_ad;
      end else if (saw_ale && !saw_stb && !(xb_rd || xb_wr)) begin
        lo_cnt++;
      end
      if (xb_rd || xb_wr) begin
        saw_stb = 1; e_wr = xb_wr; e_upper = xb_upper; e_data = xb_ad;
        e_addr = saw_ale ? {xb_ahi, lat_lo} : {xb_ahi, xb_alo};
        xb_din = ext_pat(e_addr);
      end
      if (done) begin got_done = 1; got = rdata; break; end
    end
  endtask

  task automatic t_reset;
    chk(cfg_rdata == 8'h03, "R1 reset cfg", cfg_rdata, 8'h03);
    chk(!done && !xb_ale && !ram_en, "R1 reset outputs idle", {done, xb_ale, ram_en}, 0);
    write_cfg(8'hFF);
    chk(cfg_rdata == 8'h3F, "R1 reserved bits read 0", cfg_rdata, 8'h3F);
  endtask

  task automatic t_mode00;
    write_cfg(8'h00);
    page_sel = 8'h40;
    access(1, 0, 16'h2005, 8'h77);
    chk(saw_ram && !saw_stb, "R2 above 8K stays on-chip", {saw_ram, saw_stb}, 2'b10);
    chk(r_addr == 13'h0005, "R2 alias address", r_addr, 13'h0005);
    chk(lat == 3, "R9 on-chip done latency", lat, 3);
    access(0, 1, 16'h0005, 8'h00);
    chk(saw_ram && r_addr == 13'h0005, "R2 short alias addr", r_addr, 13'h0005);
    chk(got == 8'h77, "R9 on-chip read data", got, 8'h77);
  endtask

  task automatic t_mode01;
    write_cfg(8'h14);
    hi_latch = 8'h52; page_sel = 8'h11;
    access(0, 1, 16'h0033, 8'h00);
    chk(saw_stb && !saw_ram && e_addr == 16'h5233, "R3 latch high byte", e_addr, 16'h5233);
    chk(!saw_ale && lat == 3, "R7 separate pins timing", lat, 3);
    chk(got == ext_pat(16'h5233), "R9 off-chip read data", got, ext_pat(16'h5233));
    hi_latch = 8'h1F;
    access(0, 1, 16'h0033, 8'h00);
    chk(saw_ram && !saw_stb && r_addr == 13'h1F33, "R3 below boundary on-chip", r_addr, 13'h1F33);
    access(0, 0, 16'h2000, 8'h00);
    chk(saw_stb && e_addr == 16'h2000, "R5 own upper byte at boundary", e_addr, 16'h2000);
    access(0, 0, 16'h1FFF, 8'h00);
    chk(saw_ram && !saw_stb, "R3 0x1FFF on-chip", saw_ram, 1);
  endtask

  task automatic t_mode10;
    write_cfg(8'h18);
    hi_latch = 8'h00; page_sel = 8'h81;
    access(0, 1, 16'h0044, 8'h00);
    chk(saw_stb && e_addr == 16'h8144, "R4 page high byte", e_addr, 16'h8144);
    page_sel = 8'h00;
    access(0, 1, 16'h0044, 8'h00);
    chk(saw_ram && !saw_stb && r_addr == 13'h0044, "R4 page zero on-chip", r_addr, 13'h0044);
  endtask

  task automatic t_muxed;
    for (int w = 0; w < 4; w++) begin
      write_cfg(8'h0C | 8'(w));
      access(1, 0, 16'h0123, 8'hC3);
      chk(saw_stb && !saw_ram && e_addr == 16'h0123, "R5 all off-chip addr", e_addr, 16'h0123);
      chk(hi_cnt == w + 1, "R6 latch strobe high time", hi_cnt, w + 1);
      chk(lo_cnt == w + 1, "R6 latch strobe low time", lo_cnt, w + 1);
      chk(lat == 2 * w + 4, "R6 shared-bus done latency", lat, 2 * w + 4);
      chk(e_wr && e_data == 8'hC3, "R9 write data on bus", e_data, 8'hC3);
    end
  endtask

  task automatic t_group;
    write_cfg(8'h3C);
    access(0, 0, 16'h4000, 8'h00);
    chk(e_upper == 1'b1, "R8 upper port group", e_upper, 1);
    write_cfg(8'h1C);
    access(0, 0, 16'h4000, 8'h00);
    chk(e_upper == 1'b0, "R8 lower port group", e_upper, 0);
  endtask

  task automatic t_nomux_width;
    write_cfg(8'h1F);
    access(0, 0, 16'hABCD, 8'h00);
    chk(!saw_ale && lat == 3 && e_addr == 16'hABCD, "R7 width ignored", lat, 3);
  endtask

  task automatic t_midchange;
    write_cfg(8'h0F);
    fork
      access(0, 0, 16'h0100, 8'h00);
      begin
        repeat (2) @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = 8'h10;
        @(negedge clk);
        cfg_we = 1'b0;
      end
    join
    chk(saw_stb && !saw_ram && hi_cnt == 4 && lat == 10, "R10 access unchanged", lat, 10);
    chk(cfg_rdata == 8'h10, "R10 register updated", cfg_rdata, 8'h10);
    access(0, 0, 16'h0100, 8'h00);
    chk(saw_ram && !saw_stb, "R10 next access new route", saw_ram, 1);
  endtask

  initial begin
    for (int i = 0; i < 8192; i++) mem[i] = 8'(i);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_mode00();
    t_mode01();
    t_mode10();
    t_muxed();
    t_group();
    t_nomux_width();
    t_midchange();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog act=0 exp=1");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule